// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 128K words by 16 bits. The RAM is split into two independent byte lanes. Each lane is enabled by a pair of chip selects of opposite polarity. The host issues one word request at a time over a request/ready handshake, with a write flag and per-lane byte enables. The controller then plays out a read or a write cycle on the memory pins. Each phase of the cycle lasts a whole number of clocks, derived from nanosecond minimums and a clock-period parameter.

A read holds the address and selects with output enable low for the access time. It samples the bus on the last access clock and then waits through a turnaround gap while the RAM outputs float. A write drives data for one setup clock, then pulses the write strobe, then holds address, selects and data for recovery until the minimum cycle time is met. Lanes whose enable is clear are never selected. A request with no lane enabled finishes without touching the memory.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises: ready_o is 1, rdata_valid_o is 0, mem_we_n_o and mem_oe_n_o are 1, mem_dq_oe_o is 0, and every lane is deselected (mem_cs_n_o all 1, mem_cs_o all 0).
- R2: Lane i (bit 0 = data bits 7:0, bit 1 = data bits 15:8) is selected exactly when mem_cs_n_o[i] is 0 and mem_cs_o[i] is 1. The two selects of a lane are always opposite. During a cycle, only the lanes whose be_i bit was 1 at acceptance are selected.
- R3: A read holds mem_oe_n_o low and mem_we_n_o high for ceil(T_RD_NS/CLK_NS) clocks (10 at defaults). The bus is sampled on the last of those clocks. rdata_valid_o is high for exactly one clock, the clock after that sample. Bits of lanes that were not enabled read as 0.
- R4: A write holds mem_we_n_o low for max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) clocks (5 at defaults). The strobe is preceded by one setup clock and followed by hold clocks, so that the whole cycle lasts max(ceil(T_WC_NS/CLK_NS), strobe+2) clocks (10 at defaults). mem_dq_oe_o stays high for the whole write, and mem_oe_n_o stays high while the strobe is low.
- R5: mem_dq_oe_o is never high while mem_oe_n_o is low. After a read, it stays low for a turnaround of ceil(T_TA_NS/CLK_NS) clocks (4 at defaults).
- R6: A request with be_i = 00 produces no select, strobe or output enable, and ready_o stays high. If it is a read, rdata_valid_o pulses in the next clock with rdata_o = 0.
- R7: ready_o is low from the clock after acceptance until the cycle ends: 14 clocks for a read and 10 for a write at defaults.
- R8: A write with one lane enabled changes only that lane's byte in memory. A later full read returns the other byte unchanged.
- R9: mem_addr_o does not change while ready_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, accepted when ready_o is high |
| ready_o | output | 1 | Controller idle and able to accept a request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| be_i | input | 2 | Byte-lane enables, bit 0 = low byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| rdata_valid_o | output | 1 | One-clock pulse marking rdata_o valid |
| mem_addr_o | output | 17 | Memory address lines |
| mem_cs_n_o | output | 2 | Active-low select per lane |
| mem_cs_o | output | 2 | Active-high select per lane |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_oe_o | output | 1 | Enable for the controller's data-bus driver |
| mem_dq_o | output | 16 | Data driven onto the bus |
| mem_dq_i | input | 16 | Data read from the bus |

## Verification
A request is accepted on the rising edge where req_i and ready_o are both high. All memory pins come from registered state, so they change on that same edge. ready_o then stays low for 14 clocks after a read and 10 after a write. rdata_valid_o rises on the edge after the last access clock, which is inside the turnaround. For a no-lane read it rises on the edge after acceptance. The bench drives each request at a falling edge and samples every output at each following falling edge until ready_o returns. It counts strobe, enable, driver and busy clocks per transaction, and compares those counts and the captured data against values computed from the requirements.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TA,
    ST_WS,
    ST_WP,
    ST_WH
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clk_cnt(input int ns, input int period_ns);
    return max2(1, ceil_div(ns, period_ns));
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lane_select.sv
module lane_select #(
  parameter int LANES = 2
) (
  input  logic             active_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] cs_n_o,
  output logic [LANES-1:0] cs_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic sel;
    assign sel       = active_i & be_i[l];
    assign cs_o[l]   = sel;
    assign cs_n_o[l] = ~sel;
  end

endmodule

// File: rtl/dq_path.sv
module dq_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              drive_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rd_word_o
);

  assign dq_oe_o = drive_i;
  assign dq_o    = wdata_i;

  // unselected lanes float on the bus; return zero for them
  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign rd_word_o[l*LANE_W +: LANE_W] = be_i[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LANE_W  = 8,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_RD_NS = 100,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 40,
  parameter int T_WC_NS = 100,
  parameter int T_TA_NS = 40
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  output logic                      ready_o,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES-1:0]          be_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      rdata_valid_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [LANES-1:0]          mem_cs_n_o,
  output logic [LANES-1:0]          mem_cs_o,
  output logic                      mem_we_n_o,
  output logic                      mem_oe_n_o,
  output logic                      mem_dq_oe_o,
  output logic [LANES*LANE_W-1:0]   mem_dq_o,
  input  logic [LANES*LANE_W-1:0]   mem_dq_i
);

  localparam int DATA_W   = LANES * LANE_W;
  localparam int RD_CLKS  = clk_cnt(T_RD_NS, CLK_NS);
  localparam int WP_CLKS  = max2(clk_cnt(T_WP_NS, CLK_NS), clk_cnt(T_DW_NS, CLK_NS));
  localparam int WC_CLKS  = clk_cnt(T_WC_NS, CLK_NS);
  localparam int WH_CLKS  = max2(1, WC_CLKS - WP_CLKS - 1);
  localparam int TA_CLKS  = clk_cnt(T_TA_NS, CLK_NS);
  localparam int MAX_CLKS = max2(max2(RD_CLKS, WP_CLKS), max2(WH_CLKS, TA_CLKS));
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              accept;
  logic              bus_active;
  logic [DATA_W-1:0] rd_word;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = req_i && ready_o;

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept && be_i != '0) begin
        tmr_load = 1'b1;
        tmr_val  = we_i ? '0 : CNT_W'(RD_CLKS - 1);
      end
      ST_RD: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TA_CLKS - 1);
      end
      ST_WS: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CLKS - 1);
      end
      ST_WP: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WH_CLKS - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= addr_i;
          be_q    <= be_i;
          wdata_q <= wdata_i;
          if (be_i == '0) begin
            if (!we_i) begin
              rdata_q  <= '0;
              rvalid_q <= 1'b1;
            end
          end else begin
            state_q <= we_i ? ST_WS : ST_RD;
          end
        end
        ST_RD: if (tmr_done) begin
          rdata_q  <= rd_word;
          rvalid_q <= 1'b1;
          state_q  <= ST_TA;
        end
        ST_TA: if (tmr_done) state_q <= ST_IDLE;
        ST_WS: if (tmr_done) state_q <= ST_WP;
        ST_WP: if (tmr_done) state_q <= ST_WH;
        ST_WH: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_active = (state_q == ST_RD) || (state_q == ST_WS) ||
                      (state_q == ST_WP) || (state_q == ST_WH);

  lane_select #(.LANES(LANES)) u_lanes (
    .active_i (bus_active),
    .be_i     (be_q),
    .cs_n_o   (mem_cs_n_o),
    .cs_o     (mem_cs_o)
  );

  dq_path #(.LANES(LANES), .LANE_W(LANE_W)) u_dq (
    .drive_i   ((state_q == ST_WS) || (state_q == ST_WP) || (state_q == ST_WH)),
    .wdata_i   (wdata_q),
    .be_i      (be_q),
    .dq_i      (mem_dq_i),
    .dq_oe_o   (mem_dq_oe_o),
    .dq_o      (mem_dq_o),
    .rd_word_o (rd_word)
  );

  assign mem_addr_o    = addr_q;
  assign mem_oe_n_o    = (state_q != ST_RD);
  assign mem_we_n_o    = (state_q != ST_WP);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;

  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !mem_dq_oe_o); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o); // R3
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && mem_dq_oe_o)); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(mem_addr_o)); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_o == '0 && mem_we_n_o && mem_oe_n_o)); // R6
  AST_SEL_IN_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(ready_o)) |-> ((mem_cs_o & ~$past(be_i)) == '0)); // R2

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int BUSY_RD = 14;
  localparam int BUSY_WR = 10;
  localparam int WE_CLKS = 5;
  localparam int OE_CLKS = 10;

  // {wr, be[1:0], addr[5:0], wdata[15:0], expected read data[15:0]}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 2'b11, 6'd9, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 6'd3, 16'hA5C3, 16'h0000},
    {1'b0, 2'b11, 6'd3, 16'h0000, 16'hA5C3},
    {1'b1, 2'b01, 6'd3, 16'hBE11, 16'h0000},
    {1'b0, 2'b11, 6'd3, 16'h0000, 16'hA511},
    {1'b1, 2'b10, 6'd3, 16'h77EE, 16'h0000},
    {1'b0, 2'b11, 6'd3, 16'h0000, 16'h7711},
    {1'b1, 2'b00, 6'd9, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 6'd9, 16'h0000, 16'h1234},
    {1'b0, 2'b01, 6'd9, 16'h0000, 16'h0034},
    {1'b0, 2'b10, 6'd9, 16'h0000, 16'h1200}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic        ready, rvalid, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;
  logic [1:0]  cs_n, cs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n),
    .mem_cs_o(cs), .mem_we_n_o(mem_we_n), .mem_oe_n_o(mem_oe_n),
    .mem_dq_oe_o(mem_dq_oe), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i)
  );

  // behavioural RAM, 64 words deep
  always_comb begin
    for (int l = 0; l < 2; l++)
      mem_dq_i[l*8 +: 8] = (!mem_oe_n && mem_we_n && !cs_n[l] && cs[l])
                           ? mem[mem_addr[5:0]][l*8 +: 8] : 8'h00;
  end

  always @(posedge mem_we_n) begin
    if (rst_n)
      for (int l = 0; l < 2; l++)
        if (!cs_n[l] && cs[l] && mem_dq_oe) mem[mem_addr[5:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run(input bit w, input logic [1:0] b, input logic [5:0] a,
                     input logic [15:0] d, input logic [15:0] exp);
    int busy = 0, we_lo = 0, oe_lo = 0, drv = 0, nval = 0, bad_pair = 0, bad_drv = 0;
    logic [1:0] sel_seen = '0;
    logic [15:0] got = '0;
    @(negedge clk);
    req = 1'b1; we = w; be = b; addr = {11'd0, a}; wdata = d;
    @(posedge clk);
    do begin
      @(negedge clk);
      req = 1'b0;
      if (!ready) busy++;
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) drv++;
      if (rvalid) begin nval++; got = rdata; end
      if ((cs_n ^ cs) != 2'b11) bad_pair++;
      if (mem_dq_oe && !mem_oe_n) bad_drv++;
      sel_seen |= (~cs_n & cs);
    end while (!ready);
    @(negedge clk);
    if (rvalid) nval++;
    chk(bad_pair == 0, "R2 pair", bad_pair, 0);
    chk(sel_seen == b, "R2 lanes", sel_seen, b);
    chk(bad_drv == 0, "R5 drive", bad_drv, 0);
    if (b == 2'b00) begin
      chk(busy == 0 && we_lo == 0 && oe_lo == 0, "R6 idle", busy + we_lo + oe_lo, 0);
      if (!w) chk(nval == 1 && got == 16'h0, "R6 data", got, 0);
    end else if (w) begin
      chk(busy == BUSY_WR, "R7 write busy", busy, BUSY_WR);
      chk(we_lo == WE_CLKS, "R4 strobe", we_lo, WE_CLKS);
      chk(drv == BUSY_WR && oe_lo == 0, "R4 drive", drv, BUSY_WR);
    end else begin
      chk(busy == BUSY_RD, "R7 read busy", busy, BUSY_RD);
      chk(oe_lo == OE_CLKS && we_lo == 0, "R3 enable", oe_lo, OE_CLKS);
      chk(drv == 0, "R5 turnaround", drv, 0);
      chk(nval == 1, "R3 valid pulse", nval, 1);
      chk(got == exp, "R3 R8 data", got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ready && !rvalid && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 ctrl",
        {ready, rvalid, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(cs_n == 2'b11 && cs == 2'b00, "R1 lanes", {cs_n, cs}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && mem_we_n && mem_oe_n && cs == 2'b00, "R1 after release", ready, 1);
    for (int v = 0; v < NV; v++)
      run(VEC[v][40], VEC[v][39:38], VEC[v][37:32], VEC[v][31:16], VEC[v][15:0]);
    // R6 no-lane read right after the pulse
    run(1'b0, 2'b00, 6'd3, 16'h0, 16'h0);
    // R8 lane preserved in memory after partial writes
    chk(mem[3] == 16'h7711, "R8 memory", mem[3], 16'h7711);
    // R9 back-to-back request with a different address while busy
    @(negedge clk);
    req = 1'b1; we = 1'b0; be = 2'b11; addr = 17'd9;
    @(posedge clk);
    @(negedge clk);
    addr = 17'd3; req = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_addr == 17'd9, "R9 address hold", mem_addr, 9);
    req = 1'b0;
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule